// File: doc/BRIEF.md
# Camera Receiver Staged Control Register File

This block is the control register file that sits between a 32-bit register bus and the datapath of a serial camera receiver. Software writes working copies of the receiver's settings: the global control word, the PHY control word with its high-speed settle count, the configuration word with lane count and data type, the packed frame resolution, and an interrupt mask. A few of these settings take effect at once. The format-related settings wait in the working registers until software writes a self-clearing commit bit. On that commit they are copied together into a set of active outputs that feed the receiver.

A second self-clearing bit starts a soft-reset pulse of a fixed, parameter-set length towards the datapath. While that pulse is active, the enable output is held low. At commit time the data type is checked against the set of supported codes. An unsupported code is still stored and still driven to the datapath, but it raises a status output.

Reads are combinational from the address. Offsets that are not mapped read as zero and ignore writes.

Top module: `cam_rx_shadow_regs`

## Requirements
- R1: After reset every output is zero, and every mapped offset reads zero.
- R2: Working registers read back their writable fields. Unused bits read zero. The map is:
  - Offset 0x00 control: bit 0 enable, bit 8 external clock select, bit 20 32-bit alignment, bit 31 pair swap.
  - Offset 0x04 PHY: bits 4:0 lane enables, bits 31:27 settle count.
  - Offset 0x08 configuration: bits 1:0 lane count minus one, bits 7:2 data type.
  - Offset 0x10 interrupt mask: all 32 bits.
  - Offset 0x2C resolution: width in bits 31:16, height in bits 15:0.
- R3: Enable, external clock select, pair swap, lane enables and interrupt mask drive their outputs from the clock edge that accepts the write.
- R4: A write to the alignment, settle, lane count, data type or resolution fields alone leaves the active outputs unchanged.
- R5: Writing 1 to control bit 16 loads all staged fields into the active outputs on the clock edge after the write edge. Bit 16 always reads 0.
- R6: Writing 1 to control bit 4 drives `dp_reset` high for exactly RST_CYCLES cycles, starting after the write edge. Bit 4 reads 1 while the pulse runs and 0 afterwards.
- R7: While `dp_reset` is high, `rx_enable` is low, whatever the stored enable bit holds.
- R8: At commit, `rx_fmt_unsup` becomes 0 for the data types 0x1E, 0x2A, 0x2B, 0x2C and 0x30 to 0x33, and 1 for any other code. The code itself is still driven on `rx_dtype`.
- R9: Offsets other than 0x00, 0x04, 0x08, 0x10 and 0x2C read zero, and writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rx_enable | output | 1 | Receiver enable, gated by the reset pulse |
| rx_ext_clk | output | 1 | External wrapper clock select |
| rx_pol_swap | output | 1 | Differential pair polarity swap |
| rx_lane_en | output | 5 | Clock and data lane enables |
| rx_irq_mask | output | 32 | Interrupt mask |
| rx_align32 | output | 1 | Active 32-bit alignment (0 means 24-bit) |
| rx_settle | output | 5 | Active high-speed settle count |
| rx_lanes_m1 | output | 2 | Active lane count minus one |
| rx_dtype | output | 6 | Active data type code |
| rx_width | output | 16 | Active frame width |
| rx_height | output | 16 | Active frame height |
| rx_fmt_unsup | output | 1 | Committed data type is not supported |
| dp_reset | output | 1 | Soft-reset pulse to the datapath |

## Verification
A commit flop stuck high or misrouted makes the staged outputs follow the working registers. It shows up one cycle after any configuration write, before the commit is issued. An off-by-one in the reset timer changes the number of cycles `dp_reset` stays high, and counting that pulse at the port catches it. A wrong read-mux bit or a missed address decode appears at once on `bus_rdata`, since reads are combinational. A false format match flips `rx_fmt_unsup` on the edge that loads the shadow.

// File: rtl/cam_rx_regs_pkg.sv
package cam_rx_regs_pkg;

   // register byte offsets
   localparam int OFS_CTRL = 'h00;
   localparam int OFS_PHY  = 'h04;
   localparam int OFS_CFG  = 'h08;
   localparam int OFS_MASK = 'h10;
   localparam int OFS_RES  = 'h2C;

   // control word bit positions
   localparam int CTRL_EN_BIT     = 0;
   localparam int CTRL_SRST_BIT   = 4;
   localparam int CTRL_EXTCLK_BIT = 8;
   localparam int CTRL_COMMIT_BIT = 16;
   localparam int CTRL_ALIGN_BIT  = 20;
   localparam int CTRL_SWAP_BIT   = 31;

   // PHY word fields
   localparam int LANE_EN_LSB = 0;
   localparam int LANE_EN_W   = 5;
   localparam int SETTLE_LSB  = 27;
   localparam int SETTLE_W    = 5;

   // configuration word fields
   localparam int LANES_LSB = 0;
   localparam int LANES_W   = 2;
   localparam int DTYPE_LSB = 2;
   localparam int DTYPE_W   = 6;

   // resolution word fields
   localparam int DIM_W = 16;

   // supported data type codes
   localparam int DT_YUV422_8  = 'h1E;
   localparam int DT_RAW8      = 'h2A;
   localparam int DT_RAW10     = 'h2B;
   localparam int DT_RAW12     = 'h2C;
   localparam int DT_USER_BASE = 'h30;

   typedef struct packed {
      logic                align32;
      logic [SETTLE_W-1:0] settle;
      logic [LANES_W-1:0]  lanes_m1;
      logic [DTYPE_W-1:0]  dtype;
      logic [DIM_W-1:0]    width;
      logic [DIM_W-1:0]    height;
   } stage_cfg_t;

endpackage

// File: rtl/cam_rx_fmt_check.sv
module cam_rx_fmt_check
   import cam_rx_regs_pkg::*;
#(
   parameter int USER_FMTS = 4
) (
   input  logic [DTYPE_W-1:0] dtype,
   output logic               supported
);

   if (USER_FMTS < 1 || USER_FMTS > 16) begin : g_bad_user
      $error("USER_FMTS must lie in 1..16");
   end

   logic [USER_FMTS-1:0] user_hit;
   logic                 std_hit;

   for (genvar i = 0; i < USER_FMTS; i++) begin : g_user
      assign user_hit[i] = (dtype == DTYPE_W'(DT_USER_BASE + i));
   end

   always_comb begin
      std_hit = (dtype == DTYPE_W'(DT_YUV422_8)) ||
                (dtype == DTYPE_W'(DT_RAW8))     ||
                (dtype == DTYPE_W'(DT_RAW10))    ||
                (dtype == DTYPE_W'(DT_RAW12));
      supported = std_hit || (|user_hit);
   end

endmodule

// File: rtl/cam_rx_rst_timer.sv
module cam_rx_rst_timer #(
   parameter int unsigned CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("CYCLES must be at least 1");
   end

   localparam int CNT_W = $clog2(CYCLES + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (start)      cnt <= CNT_W'(CYCLES);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   // checker: length of the busy run since the last start
   logic [CNT_W:0] run_len;
   always_ff @(posedge clk) begin
      if (!rst_n)     run_len <= '0;
      else if (start) run_len <= '0;
      else if (busy)  run_len <= run_len + 1'b1;
   end

   assert_pulse_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   assert_pulse_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_len == (CNT_W+1)'(CYCLES)));

endmodule

// File: rtl/cam_rx_shadow_stage.sv
module cam_rx_shadow_stage
   import cam_rx_regs_pkg::*;
#(
   parameter bit STAGED = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       commit,
   input  stage_cfg_t work_cfg,
   input  logic       work_ok,
   output stage_cfg_t act_cfg,
   output logic       act_unsup
);

   if (STAGED) begin : g_staged
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            act_cfg   <= '0;
            act_unsup <= 1'b0;
         end else if (commit) begin
            act_cfg   <= work_cfg;
            act_unsup <= !work_ok;
         end
      end

      assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
         !commit |=> $stable(act_cfg));

      assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
         commit |=> (act_cfg == $past(work_cfg)));

      assert_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
         commit |=> (act_unsup == !$past(work_ok)));
   end else begin : g_transparent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            act_cfg   <= '0;
            act_unsup <= 1'b0;
         end else begin
            act_cfg   <= work_cfg;
            act_unsup <= !work_ok;
         end
      end
   end

endmodule

// File: rtl/cam_rx_shadow_regs.sv
module cam_rx_shadow_regs
   import cam_rx_regs_pkg::*;
#(
   parameter int          ADDR_W     = 8,
   parameter int          DATA_W     = 32,
   parameter int unsigned RST_CYCLES = 16,
   parameter int          USER_FMTS  = 4,
   parameter bit          STAGED     = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_we,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                rx_enable,
   output logic                rx_ext_clk,
   output logic                rx_pol_swap,
   output logic [LANE_EN_W-1:0] rx_lane_en,
   output logic [DATA_W-1:0]   rx_irq_mask,
   output logic                rx_align32,
   output logic [SETTLE_W-1:0] rx_settle,
   output logic [LANES_W-1:0]  rx_lanes_m1,
   output logic [DTYPE_W-1:0]  rx_dtype,
   output logic [DIM_W-1:0]    rx_width,
   output logic [DIM_W-1:0]    rx_height,
   output logic                rx_fmt_unsup,
   output logic                dp_reset
);

   if (DATA_W != 32) begin : g_bad_data
      $error("DATA_W must be 32");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must reach offset 0x2C");
   end

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_PHY  = ADDR_W'(OFS_PHY);
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_RES  = ADDR_W'(OFS_RES);

   // working registers
   logic                 w_en, w_extclk, w_swap, w_align;
   logic [LANE_EN_W-1:0] w_lane_en;
   logic [SETTLE_W-1:0]  w_settle;
   logic [LANES_W-1:0]   w_lanes;
   logic [DTYPE_W-1:0]   w_dtype;
   logic [DIM_W-1:0]     w_width, w_height;
   logic [DATA_W-1:0]    w_mask;
   logic                 commit_q;

   logic sel_ctrl, sel_phy, sel_cfg, sel_mask, sel_res, addr_mapped;

   always_comb begin
      sel_ctrl    = bus_we && (bus_addr == A_CTRL);
      sel_phy     = bus_we && (bus_addr == A_PHY);
      sel_cfg     = bus_we && (bus_addr == A_CFG);
      sel_mask    = bus_we && (bus_addr == A_MASK);
      sel_res     = bus_we && (bus_addr == A_RES);
      addr_mapped = (bus_addr == A_CTRL) || (bus_addr == A_PHY) ||
                    (bus_addr == A_CFG)  || (bus_addr == A_MASK) ||
                    (bus_addr == A_RES);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         w_en      <= 1'b0;
         w_extclk  <= 1'b0;
         w_swap    <= 1'b0;
         w_align   <= 1'b0;
         w_lane_en <= '0;
         w_settle  <= '0;
         w_lanes   <= '0;
         w_dtype   <= '0;
         w_width   <= '0;
         w_height  <= '0;
         w_mask    <= '0;
         commit_q  <= 1'b0;
      end else begin
         commit_q <= sel_ctrl && bus_wdata[CTRL_COMMIT_BIT];
         if (sel_ctrl) begin
            w_en     <= bus_wdata[CTRL_EN_BIT];
            w_extclk <= bus_wdata[CTRL_EXTCLK_BIT];
            w_swap   <= bus_wdata[CTRL_SWAP_BIT];
            w_align  <= bus_wdata[CTRL_ALIGN_BIT];
         end
         if (sel_phy) begin
            w_lane_en <= bus_wdata[LANE_EN_LSB +: LANE_EN_W];
            w_settle  <= bus_wdata[SETTLE_LSB +: SETTLE_W];
         end
         if (sel_cfg) begin
            w_lanes <= bus_wdata[LANES_LSB +: LANES_W];
            w_dtype <= bus_wdata[DTYPE_LSB +: DTYPE_W];
         end
         if (sel_mask) w_mask <= bus_wdata;
         if (sel_res) begin
            w_width  <= bus_wdata[DIM_W +: DIM_W];
            w_height <= bus_wdata[0 +: DIM_W];
         end
      end
   end

   // soft-reset pulse
   logic srst_start, srst_busy;
   assign srst_start = sel_ctrl && bus_wdata[CTRL_SRST_BIT];

   cam_rx_rst_timer #(.CYCLES(RST_CYCLES)) u_rst (
      .clk   (clk),
      .rst_n (rst_n),
      .start (srst_start),
      .busy  (srst_busy)
   );

   // format check and shadow stage
   stage_cfg_t work_cfg, act_cfg;
   logic       work_ok, act_unsup;

   always_comb begin
      work_cfg          = '0;
      work_cfg.align32  = w_align;
      work_cfg.settle   = w_settle;
      work_cfg.lanes_m1 = w_lanes;
      work_cfg.dtype    = w_dtype;
      work_cfg.width    = w_width;
      work_cfg.height   = w_height;
   end

   cam_rx_fmt_check #(.USER_FMTS(USER_FMTS)) u_fmt (
      .dtype     (w_dtype),
      .supported (work_ok)
   );

   cam_rx_shadow_stage #(.STAGED(STAGED)) u_shadow (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit    (commit_q),
      .work_cfg  (work_cfg),
      .work_ok   (work_ok),
      .act_cfg   (act_cfg),
      .act_unsup (act_unsup)
   );

   // outputs
   assign dp_reset     = srst_busy;
   assign rx_enable    = w_en && !srst_busy;
   assign rx_ext_clk   = w_extclk;
   assign rx_pol_swap  = w_swap;
   assign rx_lane_en   = w_lane_en;
   assign rx_irq_mask  = w_mask;
   assign rx_align32   = act_cfg.align32;
   assign rx_settle    = act_cfg.settle;
   assign rx_lanes_m1  = act_cfg.lanes_m1;
   assign rx_dtype     = act_cfg.dtype;
   assign rx_width     = act_cfg.width;
   assign rx_height    = act_cfg.height;
   assign rx_fmt_unsup = act_unsup;

   // read mux
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL: begin
            bus_rdata[CTRL_EN_BIT]     = w_en;
            bus_rdata[CTRL_SRST_BIT]   = srst_busy;
            bus_rdata[CTRL_EXTCLK_BIT] = w_extclk;
            bus_rdata[CTRL_ALIGN_BIT]  = w_align;
            bus_rdata[CTRL_SWAP_BIT]   = w_swap;
         end
         A_PHY: begin
            bus_rdata[LANE_EN_LSB +: LANE_EN_W] = w_lane_en;
            bus_rdata[SETTLE_LSB +: SETTLE_W]   = w_settle;
         end
         A_CFG: begin
            bus_rdata[LANES_LSB +: LANES_W] = w_lanes;
            bus_rdata[DTYPE_LSB +: DTYPE_W] = w_dtype;
         end
         A_MASK:  bus_rdata = w_mask;
         A_RES:   bus_rdata = {w_width, w_height};
         default: bus_rdata = '0;
      endcase
   end

   assert_en_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dp_reset |-> !rx_enable);

   assert_ctrl_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sel_ctrl |=> (rx_ext_clk == $past(bus_wdata[CTRL_EXTCLK_BIT])));

   assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !addr_mapped) |=> ($stable(rx_lane_en) && $stable(rx_irq_mask)));

   always_comb begin
      if (rst_n && !addr_mapped) begin
         assert_unmapped_read_R9: assert (bus_rdata == '0);
      end
   end

endmodule

// File: tb/cam_rx_shadow_regs_test.sv
module cam_rx_shadow_regs_test;

   localparam int RSTN = 16;
   localparam int NV   = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rx_enable, rx_ext_clk, rx_pol_swap, rx_align32, rx_fmt_unsup, dp_reset;
   logic [4:0]  rx_lane_en, rx_settle;
   logic [31:0] rx_irq_mask;
   logic [1:0]  rx_lanes_m1;
   logic [5:0]  rx_dtype;
   logic [15:0] rx_width, rx_height;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cam_rx_shadow_regs #(.RST_CYCLES(RSTN)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_enable(rx_enable),
      .rx_ext_clk(rx_ext_clk), .rx_pol_swap(rx_pol_swap), .rx_lane_en(rx_lane_en),
      .rx_irq_mask(rx_irq_mask), .rx_align32(rx_align32), .rx_settle(rx_settle),
      .rx_lanes_m1(rx_lanes_m1), .rx_dtype(rx_dtype), .rx_width(rx_width),
      .rx_height(rx_height), .rx_fmt_unsup(rx_fmt_unsup), .dp_reset(dp_reset)
   );

   // {addr, write data, expected readback}
   localparam logic [71:0] VECS [NV] = '{
      {8'h00, 32'h8010_0101, 32'h8010_0101},
      {8'h04, 32'hAAAA_AAAA, 32'hA800_000A},
      {8'h04, 32'hF800_001F, 32'hF800_001F},
      {8'h08, 32'hFFFF_FFFF, 32'h0000_00FF},
      {8'h08, 32'h0000_00B9, 32'h0000_00B9},
      {8'h10, 32'hF000_103F, 32'hF000_103F},
      {8'h2C, 32'h1234_5678, 32'h1234_5678},
      {8'h0C, 32'hFFFF_FFFF, 32'h0000_0000},
      {8'h14, 32'hFFFF_FFFF, 32'h0000_0000},
      {8'h3C, 32'hFFFF_FFFF, 32'h0000_0000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic do_reset;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic commit_fmt(input logic [31:0] cfg);
      wr(8'h08, cfg);
      wr(8'h00, 32'h0011_0001);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      logic [31:0] snap [5];
      int n;
      do_reset();

      // R1: reset state
      chk("R1 outputs", {rx_enable, rx_ext_clk, rx_pol_swap, rx_align32, rx_fmt_unsup,
                         dp_reset, rx_lane_en, rx_settle, rx_lanes_m1, rx_dtype}, 32'h0);
      chk("R1 dims", {rx_width, rx_height}, 32'h0);
      chk("R1 mask", rx_irq_mask, 32'h0);
      foreach (snap[i]) begin
         rd(i == 4 ? 8'h2C : (i == 3 ? 8'h10 : 8'(i * 4)), r);
         chk("R1 read", r, 32'h0);
      end

      // vector table: R2 readback, R9 unmapped
      for (int i = 0; i < NV; i++) begin
         wr(VECS[i][71:64], VECS[i][63:32]);
         rd(VECS[i][71:64], r);
         if (VECS[i][71:64] inside {8'h00, 8'h04, 8'h08, 8'h10, 8'h2C})
            chk("R2 readback", r, VECS[i][31:0]);
         else
            chk("R9 unmapped read", r, VECS[i][31:0]);
      end

      do_reset();

      // R3 immediate, R4 staged hold
      wr(8'h08, 32'h0000_00AF);          // dtype 0x2B, lanes-1 = 3
      wr(8'h2C, 32'h0780_0438);
      wr(8'h04, 32'h6800_001F);          // settle 0x0D, all lanes
      wr(8'h00, 32'h0010_0001);          // align32 + enable
      chk("R3 enable", rx_enable, 1);
      chk("R3 lane_en", rx_lane_en, 5'h1F);
      wr(8'h10, 32'h0000_0005);
      chk("R3 irq mask", rx_irq_mask, 32'h5);
      chk("R4 held", {rx_align32, rx_settle, rx_lanes_m1, rx_dtype}, 32'h0);
      chk("R4 held dims", {rx_width, rx_height}, 32'h0);

      // R5 commit timing
      wr(8'h00, 32'h0011_0001);
      chk("R5 not yet", rx_dtype, 6'h0);
      @(negedge clk);
      chk("R5 dtype", rx_dtype, 6'h2B);
      chk("R5 lanes", rx_lanes_m1, 2'd3);
      chk("R5 dims", {rx_width, rx_height}, 32'h0780_0438);
      chk("R5 settle", rx_settle, 5'h0D);
      chk("R5 align", rx_align32, 1);
      chk("R8 raw10 ok", rx_fmt_unsup, 0);
      rd(8'h00, r);
      chk("R5 bit16 reads 0", r, 32'h0010_0001);

      // R4 again: a later write does not reach the outputs
      wr(8'h08, 32'h0000_00FD);
      repeat (3) @(negedge clk);
      chk("R4 dtype held", rx_dtype, 6'h2B);
      rd(8'h08, r);
      chk("R2 cfg", r, 32'h0000_00FD);
      wr(8'h00, 32'h0011_0001);
      @(negedge clk);
      chk("R8 code 0x3F stored", rx_dtype, 6'h3F);
      chk("R8 code 0x3F flagged", rx_fmt_unsup, 1);

      // R8 boundary codes
      commit_fmt(32'h0000_00CC);        // 0x33
      chk("R8 user4 ok", rx_fmt_unsup, 0);
      commit_fmt(32'h0000_00D0);        // 0x34
      chk("R8 0x34 flagged", rx_fmt_unsup, 1);
      commit_fmt(32'h0000_0078);        // 0x1E
      chk("R8 yuv ok", rx_fmt_unsup, 0);
      commit_fmt(32'h0000_00B4);        // 0x2D
      chk("R8 0x2D flagged", rx_fmt_unsup, 1);

      // R6 / R7 soft reset pulse
      wr(8'h00, 32'h0010_0011);
      rd(8'h00, r);
      chk("R6 bit4 busy", r, 32'h0010_0011);
      n = 0;
      while (dp_reset && n < 100) begin
         n++;
         if (rx_enable) chk("R7 enable gated", rx_enable, 0);
         @(negedge clk);
      end
      chk("R6 pulse length", n, RSTN);
      chk("R7 enable back", rx_enable, 1);
      rd(8'h00, r);
      chk("R6 bit4 cleared", r, 32'h0010_0001);

      // R3 swap / ext clock
      wr(8'h00, 32'h8010_0101);
      chk("R3 swap", rx_pol_swap, 1);
      chk("R3 ext clk", rx_ext_clk, 1);

      // R9 unmapped writes
      rd(8'h00, snap[0]); rd(8'h04, snap[1]); rd(8'h08, snap[2]);
      rd(8'h10, snap[3]); rd(8'h2C, snap[4]);
      wr(8'h0C, 32'hFFFF_FFFF);
      wr(8'h3C, 32'hFFFF_FFFF);
      wr(8'h14, 32'hFFFF_FFFF);
      rd(8'h00, r); chk("R9 ctrl kept", r, snap[0]);
      rd(8'h04, r); chk("R9 phy kept", r, snap[1]);
      rd(8'h08, r); chk("R9 cfg kept", r, snap[2]);
      rd(8'h10, r); chk("R9 mask kept", r, snap[3]);
      rd(8'h2C, r); chk("R9 res kept", r, snap[4]);
      chk("R9 no pulse", dp_reset, 0);
      chk("R9 mask out", rx_irq_mask, 32'h5);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule